// File: doc/BRIEF.md
# Serial LED Cascade Driver

This peripheral drives a chain of external 8-bit shift registers over three wires: a serial data line, a shift clock and a store strobe. Software writes a 24-bit output image through a small word-addressed register bus. It then asks for an update, and the block shifts the active part of the image out one bit at a time, most significant bit first. When the last bit is out, it pulses the store strobe for one cycle so that the external registers present the new pattern on their outputs.

The low eight output bits can each be handed to a hardware status source instead of software: two modem link bits (outputs 0 and 1), a three-bit port status group (outputs 2 to 4) and a second three-bit group (outputs 5 to 7). When any bit is hardware-owned and automatic refresh is on, an internal timer restarts the frame at one of four selectable rates, so the external pattern follows the status inputs without any software action. The shift clock rate, the capture edge of the external registers and the number of active byte groups are all set in a configuration register.

Register map (word offsets): 0x0 output image (bits 23:0); 0x4 configuration (bits 2:0 group enables, bit 3 falling-edge capture, bits 5:4 refresh rate, bit 6 automatic refresh, bits 15:8 half-period divider); 0x8 hardware ownership mask (bits 7:0); 0xC command (writing bit 0 as one requests an update; reads as zero).

Top module: `stp_led_chain`

## Requirements
- R1: After reset every register reads zero, the shift clock is low, serial data is low and the store strobe is low.
- R2: Reading offset 0x0 returns the image last written by software, whatever the ownership mask and status inputs are.
- R3: A frame shifts exactly 8 times the position of the highest set group enable (bit 0 gives 8, bit 1 gives 16, bit 2 gives 24); with no group enabled an update request produces no frame.
- R4: Bits leave most significant first, starting at bit (count-1) and ending with bit 0; an output bit i below 8 whose ownership bit is set carries status input i (bits 1:0 modem link, 4:2 first port group, 7:5 second port group), every other bit carries image bit i.
- R5: With configuration bit 3 clear the shift clock idles low and data is meant to be captured on its rising edge; with it set the clock idles high and capture is on the falling edge; serial data is stable at every capture edge.
- R6: After the last bit the store strobe is high for exactly one cycle while the shift clock sits at its idle level.
- R7: An update request that arrives while a frame is in progress is held and starts a complete second frame after the first ends.
- R8: With automatic refresh on and a non-zero ownership mask, frames repeat every 20, 10, 5 or 4 ticks for rate codes 0, 1, 2 and 3, a tick being TICK_CYCLES system clocks; with an all-zero mask no automatic frame occurs.
- R9: Consecutive capture edges within a frame are 2 x (divider + 1) system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dsl_stat | input | 2 | Modem link status for outputs 1:0 |
| phy1_stat | input | 3 | First port status group for outputs 4:2 |
| phy2_stat | input | 3 | Second port status group for outputs 7:5 |
| ser_data | output | 1 | Serial data to the cascade |
| ser_clk | output | 1 | Shift clock to the cascade |
| ser_store | output | 1 | Store strobe to the cascade |

## Verification
The assertions take for granted that the configuration, and above all the group enables and the edge select, stay unchanged while a frame is on the wire; a change mid-frame would legitimately move the clock level or drop a pending request. The stimulus keeps to this by writing configuration only while the chain is idle, waiting for each store strobe before the next setting. Status inputs are changed only between frames, so the merged word the bench predicts is the one captured at frame start.

// File: rtl/stp_pkg.sv
package stp_pkg;
    localparam int NUM_GROUPS = 3;
    localparam int GROUP_BITS = 8;
    localparam int IMG_W      = NUM_GROUPS * GROUP_BITS;
    localparam int CNT_W      = $clog2(IMG_W + 1);
    localparam int HW_BITS    = 8;
    localparam int DIV_W      = 8;

    localparam logic [1:0] SEL_IMAGE = 2'd0;
    localparam logic [1:0] SEL_CFG   = 2'd1;
    localparam logic [1:0] SEL_OWN   = 2'd2;
    localparam logic [1:0] SEL_CMD   = 2'd3;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_BITS  = 2'd1,
        SH_STORE = 2'd2
    } sh_state_e;

    typedef struct packed {
        logic [DIV_W-1:0]      div;
        logic                  auto_en;
        logic [1:0]            rate;
        logic                  fall;
        logic [NUM_GROUPS-1:0] groups;
    } cfg_t;

    function automatic logic [CNT_W-1:0] frame_bits(input logic [NUM_GROUPS-1:0] g);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < NUM_GROUPS; i++) begin
            if (g[i]) n = CNT_W'((i + 1) * GROUP_BITS);
        end
        return n;
    endfunction

    function automatic logic [4:0] rate_ticks(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd20;
            2'd1:    return 5'd10;
            2'd2:    return 5'd5;
            default: return 5'd4;
        endcase
    endfunction
endpackage

// File: rtl/stp_regs.sv
module stp_regs
    import stp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [3:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [IMG_W-1:0]     image,
    output cfg_t                 cfg,
    output logic [HW_BITS-1:0]   own,
    output logic                 sw_req
);
    logic [1:0] sel;
    logic       wr;

    assign sel    = bus_addr[3:2];
    assign wr     = bus_sel && bus_we;
    assign sw_req = wr && (sel == SEL_CMD) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            image <= '0;
            cfg   <= '0;
            own   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_IMAGE: image <= bus_wdata[IMG_W-1:0];
                SEL_CFG: begin
                    cfg.groups  <= bus_wdata[NUM_GROUPS-1:0];
                    cfg.fall    <= bus_wdata[3];
                    cfg.rate    <= bus_wdata[5:4];
                    cfg.auto_en <= bus_wdata[6];
                    cfg.div     <= bus_wdata[8 +: DIV_W];
                end
                SEL_OWN:   own <= bus_wdata[HW_BITS-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_IMAGE: bus_rdata[IMG_W-1:0] = image;
            SEL_CFG: begin
                bus_rdata[NUM_GROUPS-1:0] = cfg.groups;
                bus_rdata[3]              = cfg.fall;
                bus_rdata[5:4]            = cfg.rate;
                bus_rdata[6]              = cfg.auto_en;
                bus_rdata[8 +: DIV_W]     = cfg.div;
            end
            SEL_OWN:   bus_rdata[HW_BITS-1:0] = own;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/stp_sched.sv
module stp_sched
    import stp_pkg::*;
#(
    parameter int TICK_CYCLES = 2_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_req,
    input  logic       auto_en,
    input  logic [1:0] rate,
    input  logic       own_any,
    input  logic       grp_zero,
    input  logic       busy,
    output logic       start,
    output logic       pend
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] presc;
    logic [4:0]    rcnt;
    logic [4:0]    lim;
    logic          auto_on;
    logic          tick;
    logic          fire;

    assign auto_on = auto_en && own_any;
    assign lim     = rate_ticks(rate);
    assign tick    = auto_on && (presc == PRE_LAST);
    assign fire    = tick && (rcnt >= lim - 5'd1);
    assign start   = pend && !busy && !grp_zero;

    always_ff @(posedge clk) begin
        if (rst || !auto_on) begin
            presc <= '0;
            rcnt  <= '0;
        end else if (tick) begin
            presc <= '0;
            rcnt  <= fire ? 5'd0 : rcnt + 5'd1;
        end else begin
            presc <= presc + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || grp_zero) pend <= 1'b0;
        else                 pend <= (pend && !start) || sw_req || fire;
    end
endmodule

// File: rtl/stp_shifter.sv
module stp_shifter
    import stp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IMG_W-1:0] word,
    input  logic [CNT_W-1:0] nbits,
    input  logic [DIV_W-1:0] div,
    input  logic             fall,
    output logic             sdo,
    output logic             sck,
    output logic             store,
    output logic             busy,
    output logic             phase
);
    sh_state_e        state;
    logic [IMG_W-1:0] word_q;
    logic [CNT_W-1:0] idx;
    logic [DIV_W-1:0] hcnt;

    assign sck   = phase ^ fall;
    assign store = (state == SH_STORE);
    assign busy  = (state != SH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            word_q <= '0;
            idx    <= '0;
            hcnt   <= '0;
            phase  <= 1'b0;
            sdo    <= 1'b0;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        word_q <= word;
                        idx    <= nbits - CNT_W'(1);
                        sdo    <= word[nbits - CNT_W'(1)];
                        hcnt   <= '0;
                        phase  <= 1'b0;
                        state  <= SH_BITS;
                    end
                end
                SH_BITS: begin
                    if (hcnt == div) begin
                        hcnt <= '0;
                        if (!phase) begin
                            phase <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            if (idx == '0) begin
                                state <= SH_STORE;
                            end else begin
                                idx <= idx - CNT_W'(1);
                                sdo <= word_q[idx - CNT_W'(1)];
                            end
                        end
                    end else begin
                        hcnt <= hcnt + DIV_W'(1);
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stp_led_chain.sv
module stp_led_chain
    import stp_pkg::*;
#(
    parameter int TICK_CYCLES = 2_500_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  dsl_stat,
    input  logic [2:0]  phy1_stat,
    input  logic [2:0]  phy2_stat,
    output logic        ser_data,
    output logic        ser_clk,
    output logic        ser_store
);
    logic [IMG_W-1:0]   image;
    cfg_t               cfg;
    logic [HW_BITS-1:0] own;
    logic [HW_BITS-1:0] hw_stat;
    logic [IMG_W-1:0]   merged;
    logic [CNT_W-1:0]   nbits;
    logic               sw_req;
    logic               start;
    logic               pend;
    logic               busy;
    logic               phase;

    assign hw_stat = {phy2_stat, phy1_stat, dsl_stat};
    assign nbits   = frame_bits(cfg.groups);

    for (genvar i = 0; i < IMG_W; i++) begin : g_merge
        if (i < HW_BITS) begin : g_hw
            assign merged[i] = own[i] ? hw_stat[i] : image[i];
        end else begin : g_sw
            assign merged[i] = image[i];
        end
    end

    stp_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .image     (image),
        .cfg       (cfg),
        .own       (own),
        .sw_req    (sw_req)
    );

    stp_sched #(.TICK_CYCLES(TICK_CYCLES)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .sw_req   (sw_req),
        .auto_en  (cfg.auto_en),
        .rate     (cfg.rate),
        .own_any  (|own),
        .grp_zero (cfg.groups == '0),
        .busy     (busy),
        .start    (start),
        .pend     (pend)
    );

    stp_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .word  (merged),
        .nbits (nbits),
        .div   (cfg.div),
        .fall  (cfg.fall),
        .sdo   (ser_data),
        .sck   (ser_clk),
        .store (ser_store),
        .busy  (busy),
        .phase (phase)
    );
endmodule

// File: rtl/stp_led_chain_chk.sv
module stp_led_chain_chk
    import stp_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  ser_store,
    input logic                  ser_clk,
    input logic                  ser_data,
    input logic                  phase,
    input logic                  busy,
    input logic                  start,
    input logic                  pend,
    input logic                  fall,
    input logic [NUM_GROUPS-1:0] groups
);
    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ser_store |=> !ser_store);                                   // R6
    AST_STORE_CLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        ser_store |-> (ser_clk == fall));                           // R6
    AST_START_NEEDS_GROUP: assert property (@(posedge clk) disable iff (rst)
        start |-> (groups != '0));                                  // R3
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);                                           // R7
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        (pend && busy) |=> (pend || (groups == '0)));               // R7
    AST_DATA_STABLE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $rose(phase) |-> $stable(ser_data));                        // R5
endmodule

bind stp_led_chain stp_led_chain_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_store (ser_store),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .phase     (phase),
    .busy      (busy),
    .start     (start),
    .pend      (pend),
    .fall      (cfg.fall),
    .groups    (cfg.groups)
);

// File: tb/tb_stp_led_chain.sv
module tb_stp_led_chain;
    localparam int TICK = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  dsl_stat = '0;
    logic [2:0]  phy1_stat = '0;
    logic [2:0]  phy2_stat = '0;
    logic        ser_data, ser_clk, ser_store;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    stp_led_chain #(.TICK_CYCLES(TICK)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dsl_stat(dsl_stat), .phy1_stat(phy1_stat), .phy2_stat(phy2_stat),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_store(ser_store)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // external cascade model, sampled on the falling system clock
    logic        tb_fall = 1'b0;
    logic        prev_sck = 1'b0;
    logic        prev_store = 1'b0;
    logic [23:0] shreg = '0;
    int nseen = 0, last_edge = 0, min_iv = 0, max_iv = 0;
    int frames = 0, dbl_store = 0;
    int f_bits = 0, f_min = 0, f_max = 0, f_sck = 0;
    int store_cyc = 0, store_prev = 0;
    logic [23:0] f_word = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk != prev_sck && ser_clk == !tb_fall) begin
                if (nseen > 0) begin
                    if (nseen == 1 || cyc - last_edge < min_iv) min_iv = cyc - last_edge;
                    if (nseen == 1 || cyc - last_edge > max_iv) max_iv = cyc - last_edge;
                end
                shreg = {shreg[22:0], ser_data};
                nseen++;
                last_edge = cyc;
            end
            if (ser_store) begin
                if (prev_store) dbl_store++;
                frames++;
                f_word = shreg; f_bits = nseen; f_min = min_iv; f_max = max_iv;
                f_sck = int'(ser_clk);
                store_prev = store_cyc; store_cyc = cyc;
                nseen = 0; min_iv = 0; max_iv = 0;
            end
        end
        prev_sck = ser_clk;
        prev_store = ser_store;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1; bus_we = 1'b0;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_frames(input int target, input int limit);
        for (int k = 0; k < limit && frames < target; k++) @(negedge clk);
    endtask

    function automatic logic [31:0] cfgw(input int groups, input int fall, input int rate,
                                        input int auto_en, input int div);
        return 32'((div << 8) | (auto_en << 6) | (rate << 4) | (fall << 3) | groups);
    endfunction

    function automatic int nb_of(input int g);
        return g[2] ? 24 : g[1] ? 16 : g[0] ? 8 : 0;
    endfunction

    function automatic logic [23:0] merge(input logic [23:0] img, input logic [7:0] own,
                                          input logic [7:0] hw);
        logic [23:0] m = img;
        for (int i = 0; i < 8; i++) if (own[i]) m[i] = hw[i];
        return m;
    endfunction

    initial begin
        logic [31:0] r;
        int ticks[4] = '{20, 10, 5, 4};
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [23:0] img, exp_w, mask;
        logic [7:0]  own, hw;
        int base, nb;
        int rt[4] = '{20, 10, 5, 4};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), r);
            check(r == 0, "R1 register reset", r, 0);
        end
        check(ser_clk == 0 && ser_data == 0 && ser_store == 0, "R1 pins reset",
              {ser_clk, ser_data, ser_store}, 0);

        // R2: image readback independent of ownership
        wr(4'h0, 32'h00A5C33C);
        wr(4'h8, 32'hFF);
        dsl_stat = 2'b11; phy1_stat = 3'b111; phy2_stat = 3'b111;
        rd(4'h0, r);
        check(r == 32'h00A5C33C, "R2 image readback", r, 32'h00A5C33C);
        wr(4'h8, 32'h0);

        // R3 R4 R5 R6 R9: sweep edge, divider, groups, patterns
        for (int f = 0; f < 2; f++)
        for (int dv = 0; dv < 2; dv++)
        for (int g = 0; g < 8; g++)
        for (int p = 0; p < 2; p++) begin
            img = (p == 0) ? 24'h9D36C1 : 24'h4AF25E ^ 24'(g * 24'h010203);
            own = (p == 0) ? 8'h00 : 8'hA7 ^ 8'(g);
            hw  = 8'h5C ^ 8'(dv * 8'h33 + f);
            {phy2_stat, phy1_stat, dsl_stat} = hw;
            tb_fall = f[0];
            wr(4'h4, cfgw(g, f, 0, 0, dv));
            wr(4'h0, {8'h0, img});
            wr(4'h8, {24'h0, own});
            @(negedge clk);
            check(ser_clk == f[0], "R5 idle clock level", ser_clk, f);
            base = frames;
            wr(4'hC, 32'h1);
            nb = nb_of(g);
            if (nb == 0) begin
                repeat (120) @(negedge clk);
                check(frames == base, "R3 no frame without groups", frames - base, 0);
            end else begin
                wait_frames(base + 1, 400);
                check(frames == base + 1, "R3 frame produced", frames - base, 1);
                check(f_bits == nb, "R3 bit count", f_bits, nb);
                mask = 24'((64'h1 << nb) - 1);
                exp_w = merge(img, own, hw) & mask;
                check((f_word & mask) == exp_w, "R4 shifted word", f_word & mask, exp_w);
                check(f_sck == f, "R6 clock idle at store", f_sck, f);
                check(f_min == 2 * (dv + 1) && f_max == 2 * (dv + 1), "R9 edge spacing",
                      f_max, 2 * (dv + 1));
            end
        end
        check(dbl_store == 0, "R6 store one cycle", dbl_store, 0);

        // R7: request during a frame is held
        tb_fall = 1'b0;
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0000C3);
        wr(4'h4, cfgw(1, 0, 0, 0, 1));
        base = frames;
        wr(4'hC, 32'h1);
        repeat (6) @(negedge clk);
        wr(4'hC, 32'h1);
        wait_frames(base + 2, 400);
        repeat (60) @(negedge clk);
        check(frames == base + 2, "R7 pending request frame", frames - base, 2);
        check(f_bits == 8 && f_word[7:0] == 8'hC3, "R7 second frame complete",
              {f_bits, f_word[7:0]}, {32'd8, 8'hC3});

        // R8: automatic refresh periods
        dsl_stat = 2'b10;
        wr(4'h8, 32'h3);
        for (int rc = 0; rc < 4; rc++) begin
            wr(4'h4, cfgw(1, 0, rc, 1, 0));
            base = frames;
            wait_frames(base + 3, 1000);
            check(store_cyc - store_prev == rt[rc] * TICK, "R8 refresh period",
                  store_cyc - store_prev, rt[rc] * TICK);
            check(f_word[1:0] == 2'b10, "R8 status bits refreshed", f_word[1:0], 2'b10);
            wr(4'h4, cfgw(1, 0, rc, 0, 0));
            repeat (30) @(negedge clk);
        end
        wr(4'h8, 32'h0);
        wr(4'h4, cfgw(1, 0, 3, 1, 0));
        base = frames;
        repeat (400) @(negedge clk);
        check(frames == base, "R8 no refresh with zero mask", frames - base, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule